// File: doc/BRIEF.md
# Set/Clear Interrupt Mask Controller

This block keeps the interrupt enable mask and the latched event status for the thirteen interrupt sources of a serial port. Each source is seen as a one-cycle pulse. The pulse sets a sticky status bit, and the bit stays set until software clears it. The single interrupt line is high while any status bit has its mask bit set.

Software reaches the block through a simple register bus with a write enable, an address, write data and combinational read data. The mask cannot be written directly. Bits are set through one address and cleared through another, so two agents can change different bits without a read-modify-write race. The mask is read back at a third, read-only address. Status is read at a fourth address, and writing 1s to that address clears the selected bits.

Top module: `irq_setclr_ctrl`

## Requirements
- R1: After reset every mask bit and every status bit is 0, and the interrupt output is low.
- R2: A write to offset 0x08 sets each mask bit whose write-data bit is 1. Mask bits whose write-data bit is 0 keep their value.
- R3: A write to offset 0x0C clears each mask bit whose write-data bit is 1. Mask bits whose write-data bit is 0 keep their value.
- R4: The mask changes only through writes to 0x08 and 0x0C. A write to the mask read address 0x10, to the status address 0x14 or to any other address leaves the mask unchanged.
- R5: A pulse on source input bit i sets status bit i on the next clock, whether or not mask bit i is set. The bit then stays set with no further pulses. Source bit order: 0 receive trigger, 1 receive empty, 2 receive full, 3 transmit empty, 4 transmit full, 5 receive overrun, 6 framing error, 7 parity error, 8 receive timeout, 9 modem status change, 10 transmit trigger, 11 transmit nearly full, 12 transmit overrun.
- R6: A write to offset 0x14 clears each status bit whose write-data bit is 1. Status bits whose write-data bit is 0 keep their value.
- R7: When a source pulse and a clearing write for the same status bit arrive in the same cycle, the bit is set after that clock.
- R8: The interrupt output is high exactly when some bit is set in both status and mask, with no added cycle of delay (default variant).
- R9: Read data at 0x10 returns the mask in bits 12:0, and read data at 0x14 returns the status in bits 12:0. All bits above 12 read 0, and every other address reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| wr_en_i | input | 1 | Register write strobe |
| addr_i | input | 8 | Register byte address |
| wdata_i | input | 32 | Write data |
| src_pulse_i | input | 13 | Interrupt source pulses, one bit per source |
| rdata_o | output | 32 | Read data for addr_i |
| irq_o | output | 1 | Interrupt request |

## Verification
The embedded assertions check, on every cycle, that an enable write leaves all of its 1 bits set in the mask, that a disable write leaves them clear, and that the mask stays stable when neither of those writes occurs. They also check that every source pulse is latched into status, that a clearing write drops the bits with no pulse in the same cycle, and that the interrupt stays low while status is empty. Only the bench scenarios can show the exact read-back values, the zero upper bits and unmapped addresses, and that a clear to one bit spares the others. The same holds for the pulse-beats-clear collision and the interrupt level under mixed random mask and status patterns.

// File: rtl/irq_setclr_pkg.sv
package irq_setclr_pkg;

   // Source bit positions (software decodes status in this order)
   typedef enum int unsigned {
      SRC_RX_TRIG    = 0,
      SRC_RX_EMPTY   = 1,
      SRC_RX_FULL    = 2,
      SRC_TX_EMPTY   = 3,
      SRC_TX_FULL    = 4,
      SRC_RX_OVERRUN = 5,
      SRC_FRAME_ERR  = 6,
      SRC_PARITY_ERR = 7,
      SRC_RX_TIMEOUT = 8,
      SRC_MODEM_CHG  = 9,
      SRC_TX_TRIG    = 10,
      SRC_TX_NFULL   = 11,
      SRC_TX_OVERRUN = 12
   } irq_src_e;

   localparam int unsigned IRQ_SRC_COUNT = 13;

   // One-hot register selection produced by the address decoder
   typedef struct packed {
      logic set_mask;
      logic clr_mask;
      logic rd_mask;
      logic status;
   } reg_sel_t;

endpackage

// File: rtl/irq_setclr_decode.sv
module irq_setclr_decode
   import irq_setclr_pkg::*;
#(
   parameter int unsigned   ADDR_W   = 8,
   parameter logic [ADDR_W-1:0] SET_OFS  = 'h08,
   parameter logic [ADDR_W-1:0] CLR_OFS  = 'h0C,
   parameter logic [ADDR_W-1:0] MASK_OFS = 'h10,
   parameter logic [ADDR_W-1:0] STAT_OFS = 'h14
) (
   input  logic [ADDR_W-1:0] addr_i,
   input  logic              wr_en_i,
   output reg_sel_t          sel_o,
   output reg_sel_t          wr_o
);

   generate
      if (SET_OFS[1:0] != 2'b00 || CLR_OFS[1:0] != 2'b00 ||
          MASK_OFS[1:0] != 2'b00 || STAT_OFS[1:0] != 2'b00) begin : g_bad_align
         $error("register offsets must be word aligned");
      end
      if (SET_OFS == CLR_OFS || SET_OFS == MASK_OFS || SET_OFS == STAT_OFS ||
          CLR_OFS == MASK_OFS || CLR_OFS == STAT_OFS ||
          MASK_OFS == STAT_OFS) begin : g_bad_unique
         $error("register offsets must be distinct");
      end
   endgenerate

   always_comb begin
      sel_o.set_mask = (addr_i == SET_OFS);
      sel_o.clr_mask = (addr_i == CLR_OFS);
      sel_o.rd_mask  = (addr_i == MASK_OFS);
      sel_o.status   = (addr_i == STAT_OFS);
   end

   assign wr_o = wr_en_i ? sel_o : '0;

endmodule

// File: rtl/irq_setclr_mask.sv
module irq_setclr_mask #(
   parameter int unsigned N = 13
) (
   input  logic         clk_i,
   input  logic         rst_ni,
   input  logic         set_we_i,
   input  logic         clr_we_i,
   input  logic [N-1:0] bits_i,
   output logic [N-1:0] mask_o
);

   logic [N-1:0] mask_q;

   generate
      for (genvar i = 0; i < N; i++) begin : g_bit
         always_ff @(posedge clk_i or negedge rst_ni) begin
            if (!rst_ni) begin
               mask_q[i] <= 1'b0;
            end else if (set_we_i && bits_i[i]) begin
               mask_q[i] <= 1'b1;
            end else if (clr_we_i && bits_i[i]) begin
               mask_q[i] <= 1'b0;
            end
         end
      end
   endgenerate

   assign mask_o = mask_q;

   // R2: every 1 written to the set address is present afterwards
   a_r2_set_bits: assert property (@(posedge clk_i) disable iff (!rst_ni)
      set_we_i |=> ((mask_q & $past(bits_i)) == $past(bits_i)));

   // R3: every 1 written to the clear address is absent afterwards
   a_r3_clr_bits: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (clr_we_i && !set_we_i) |=> ((mask_q & $past(bits_i)) == '0));

   // R4: no set or clear write means a stable mask
   a_r4_mask_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (!set_we_i && !clr_we_i) |=> $stable(mask_q));

endmodule

// File: rtl/irq_setclr_status.sv
module irq_setclr_status #(
   parameter int unsigned N = 13
) (
   input  logic         clk_i,
   input  logic         rst_ni,
   input  logic [N-1:0] src_i,
   input  logic         clr_we_i,
   input  logic [N-1:0] clr_bits_i,
   output logic [N-1:0] status_o
);

   logic [N-1:0] stat_q;
   logic [N-1:0] clr_vec;

   assign clr_vec = clr_we_i ? clr_bits_i : '0;

   generate
      for (genvar i = 0; i < N; i++) begin : g_bit
         always_ff @(posedge clk_i or negedge rst_ni) begin
            if (!rst_ni) begin
               stat_q[i] <= 1'b0;
            end else if (src_i[i]) begin
               stat_q[i] <= 1'b1;   // a new event wins over a clear
            end else if (clr_vec[i]) begin
               stat_q[i] <= 1'b0;
            end
         end
      end
   endgenerate

   assign status_o = stat_q;

   // R5 / R7: every pulse is latched, clear or not
   a_r5_pulse_latched: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (|src_i) |=> ((stat_q & $past(src_i)) == $past(src_i)));

   // R6: cleared bits without a simultaneous pulse drop to 0
   a_r6_clear_drops: assert property (@(posedge clk_i) disable iff (!rst_ni)
      clr_we_i |=> ((stat_q & $past(clr_bits_i & ~src_i)) == '0));

endmodule

// File: rtl/irq_setclr_ctrl.sv
module irq_setclr_ctrl
   import irq_setclr_pkg::*;
#(
   parameter int unsigned N_SRC   = IRQ_SRC_COUNT,
   parameter int unsigned ADDR_W  = 8,
   parameter int unsigned DATA_W  = 32,
   parameter bit          IRQ_REG = 1'b0
) (
   input  logic              clk_i,
   input  logic              rst_ni,
   input  logic              wr_en_i,
   input  logic [ADDR_W-1:0] addr_i,
   input  logic [DATA_W-1:0] wdata_i,
   input  logic [N_SRC-1:0]  src_pulse_i,
   output logic [DATA_W-1:0] rdata_o,
   output logic              irq_o
);

   localparam int unsigned PAD_W = DATA_W - N_SRC;

   generate
      if (N_SRC < 1 || N_SRC > DATA_W) begin : g_bad_nsrc
         $error("N_SRC must lie between 1 and DATA_W");
      end
      if (ADDR_W < 5) begin : g_bad_addr
         $error("ADDR_W too narrow for the register offsets");
      end
   endgenerate

   reg_sel_t            sel;
   reg_sel_t            wr;
   logic [N_SRC-1:0]    mask;
   logic [N_SRC-1:0]    status;
   logic [N_SRC-1:0]    wbits;
   logic                irq_comb;

   assign wbits = wdata_i[N_SRC-1:0];

   irq_setclr_decode #(
      .ADDR_W   (ADDR_W),
      .SET_OFS  (ADDR_W'('h08)),
      .CLR_OFS  (ADDR_W'('h0C)),
      .MASK_OFS (ADDR_W'('h10)),
      .STAT_OFS (ADDR_W'('h14))
   ) u_decode (
      .addr_i  (addr_i),
      .wr_en_i (wr_en_i),
      .sel_o   (sel),
      .wr_o    (wr)
   );

   irq_setclr_mask #(.N(N_SRC)) u_mask (
      .clk_i    (clk_i),
      .rst_ni   (rst_ni),
      .set_we_i (wr.set_mask),
      .clr_we_i (wr.clr_mask),
      .bits_i   (wbits),
      .mask_o   (mask)
   );

   irq_setclr_status #(.N(N_SRC)) u_status (
      .clk_i      (clk_i),
      .rst_ni     (rst_ni),
      .src_i      (src_pulse_i),
      .clr_we_i   (wr.status),
      .clr_bits_i (wbits),
      .status_o   (status)
   );

   // Read mux: only the mask and status addresses return data
   logic [N_SRC-1:0] rd_bits;
   always_comb begin
      rd_bits = '0;
      if (sel.rd_mask) rd_bits = mask;
      if (sel.status)  rd_bits = status;
   end

   generate
      if (PAD_W > 0) begin : g_pad
         assign rdata_o = {{PAD_W{1'b0}}, rd_bits};
      end else begin : g_nopad
         assign rdata_o = rd_bits;
      end
   endgenerate

   assign irq_comb = |(status & mask);

   generate
      if (IRQ_REG) begin : g_irq_flop
         logic irq_q;
         always_ff @(posedge clk_i or negedge rst_ni) begin
            if (!rst_ni) irq_q <= 1'b0;
            else         irq_q <= irq_comb;
         end
         assign irq_o = irq_q;
      end else begin : g_irq_comb
         assign irq_o = irq_comb;

         // R8: empty status can never raise the line
         a_r8_quiet_when_empty: assert property (@(posedge clk_i) disable iff (!rst_ni)
            (status == '0) |-> !irq_o);
      end
   endgenerate

   // R9: upper read bits are always zero
   a_r9_upper_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (rdata_o >> N_SRC) == '0);

endmodule

// File: tb/irq_setclr_ctrl_tb.sv
`timescale 1ns/1ps
module irq_setclr_ctrl_tb;

   localparam int N = 13;
   localparam logic [7:0] A_SET  = 8'h08;
   localparam logic [7:0] A_CLR  = 8'h0C;
   localparam logic [7:0] A_MASK = 8'h10;
   localparam logic [7:0] A_STAT = 8'h14;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        we = 1'b0;
   logic [7:0]  addr = '0;
   logic [31:0] wdata = '0;
   logic [N-1:0] src = '0;
   logic [31:0] rdata;
   logic        irq;

   int n_run = 0;
   int n_fail = 0;
   logic [N-1:0] m_mask = '0;
   logic [N-1:0] m_stat = '0;

   always #2.5 clk = ~clk;

   irq_setclr_ctrl u_dut (
      .clk_i(clk), .rst_ni(rst_n), .wr_en_i(we), .addr_i(addr),
      .wdata_i(wdata), .src_pulse_i(src), .rdata_o(rdata), .irq_o(irq)
   );

   function automatic logic [N-1:0] next_mask(logic [N-1:0] m, logic w,
                                              logic [7:0] a, logic [31:0] d);
      if (w && a == A_SET) return m | d[N-1:0];
      if (w && a == A_CLR) return m & ~d[N-1:0];
      return m;
   endfunction

   function automatic logic [N-1:0] next_stat(logic [N-1:0] s, logic w,
                                              logic [7:0] a, logic [31:0] d,
                                              logic [N-1:0] p);
      logic [N-1:0] c;
      c = (w && a == A_STAT) ? d[N-1:0] : '0;
      return (s & ~c) | p;
   endfunction

   task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
      n_run++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   task automatic cyc(logic w, logic [7:0] a, logic [31:0] d, logic [N-1:0] p);
      @(negedge clk);
      we = w; addr = a; wdata = d; src = p;
      m_mask = next_mask(m_mask, w, a, d);
      m_stat = next_stat(m_stat, w, a, d, p);
      @(posedge clk);
      #1;
      we = 1'b0; src = '0;
   endtask

   task automatic rd(logic [7:0] a, output logic [31:0] v);
      @(negedge clk);
      we = 1'b0; src = '0; addr = a;
      #1 v = rdata;
   endtask

   task automatic check_all(string tag);
      logic [31:0] v;
      rd(A_MASK, v); chk({tag, " mask"}, v, {19'd0, m_mask});
      rd(A_STAT, v); chk({tag, " status"}, v, {19'd0, m_stat});
      chk({tag, " R8 irq"}, {31'd0, irq}, {31'd0, |(m_mask & m_stat)});
   endtask

   initial begin : wdog
      #(5.0 * 100000);
      n_fail++;
      $display("FAIL watchdog: actual timeout expected finish");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end

   initial begin : main
      logic [31:0] v;
      int unsigned seed;
      seed = 32'd1234;
      void'($urandom(seed));

      // R1 reset state, with pulses during reset ignored
      src = '1;
      repeat (3) @(posedge clk);
      @(negedge clk); src = '0; rst_n = 1'b1;
      check_all("R1");
      chk("R1 irq low", {31'd0, irq}, 32'd0);

      // R2 set only 1 bits
      cyc(1, A_SET, 32'h0000_0005, '0);
      cyc(1, A_SET, 32'h0000_1010, '0);
      rd(A_MASK, v); chk("R2 set accumulates", v, 32'h0000_1015);
      check_all("R2");

      // R3 clear only 1 bits
      cyc(1, A_CLR, 32'h0000_0011, '0);
      rd(A_MASK, v); chk("R3 clear selected", v, 32'h0000_1004);

      // R4 writes elsewhere do not touch mask
      cyc(1, A_MASK, 32'hFFFF_FFFF, '0);
      cyc(1, 8'h00, 32'hFFFF_FFFF, '0);
      cyc(1, A_STAT, 32'hFFFF_FFFF, '0);
      rd(A_MASK, v); chk("R4 mask read-only", v, 32'h0000_1004);

      // R5 pulse on an unmasked source (framing error, bit 6) latches, no irq
      cyc(0, 8'h00, 0, 13'h0040);
      rd(A_STAT, v); chk("R5 latch unmasked", v, 32'h0000_0040);
      chk("R8 masked no irq", {31'd0, irq}, 32'd0);
      repeat (3) cyc(0, 8'h00, 0, '0);
      rd(A_STAT, v); chk("R5 sticky", v, 32'h0000_0040);
      // R5 bit 12 (transmit overrun) is masked on -> irq
      cyc(0, 8'h00, 0, 13'h1000);
      rd(A_STAT, v); chk("R5 bit12", v, 32'h0000_1040);
      chk("R8 irq high", {31'd0, irq}, 32'd1);

      // R6 clear one bit only
      cyc(1, A_STAT, 32'h0000_1000, '0);
      rd(A_STAT, v); chk("R6 w1c selective", v, 32'h0000_0040);
      chk("R8 irq drops", {31'd0, irq}, 32'd0);

      // R7 pulse and clear together
      cyc(1, A_STAT, 32'h0000_0041, 13'h0001);
      rd(A_STAT, v); chk("R7 pulse beats clear", v, 32'h0000_0001);

      // R9 unmapped and write-only addresses read 0
      rd(A_SET, v); chk("R9 set addr reads 0", v, 32'd0);
      rd(A_CLR, v); chk("R9 clr addr reads 0", v, 32'd0);
      rd(8'h30, v); chk("R9 other reads 0", v, 32'd0);

      // Random mix
      for (int i = 0; i < 400; i++) begin
         logic [7:0] a;
         logic [31:0] d;
         logic [N-1:0] p;
         case ($urandom_range(0, 5))
            0: a = A_SET;
            1: a = A_CLR;
            2: a = A_STAT;
            3: a = A_MASK;
            4: a = 8'h04;
            default: a = 8'h14;
         endcase
         d = $urandom();
         p = ($urandom_range(0, 3) == 0) ? N'($urandom()) & N'($urandom()) : '0;
         cyc($urandom_range(0, 1) == 1, a, d, p);
         if (i % 8 == 0) check_all("R2 R3 R4 R5 R6 R7 R9 random");
         else chk("R8 random irq", {31'd0, irq}, {31'd0, |(m_mask & m_stat)});
      end

      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end

endmodule